// File: doc/BRIEF.md
# Paged External RAM Address Extender

This block joins an 8-bit microcontroller bus, with its 16-bit address space, to a 256 KB byte-wide external RAM that needs 18 address lines. The processor puts the low address byte on a pin group that it shares with data, marks it with an address strobe (ALE), and keeps the high address byte on pins of its own. The block catches the low byte while ALE is high and keeps it on the RAM address lines for the rest of the bus cycle. It passes the high byte straight through. It adds two more address lines, taken from a page register, so that all 256 KB can be reached.

The page register sits at one decoded address in I/O space, and software writes it there. A configurable memory window is shared between on-chip RAM and the external RAM. When the page is zero, the on-chip RAM answers in that window. On any other page the external RAM takes the window. The page register resets to zero, so the processor starts with the window on internal RAM. The external data path is always one byte wide.

Top module: `paged_xram_bridge`

## Requirements
- R1: While `mcu_ale` is high, `ram_a[7:0]` follows `mcu_ad_i` combinationally, including changes made during the ALE phase.
- R2: After `mcu_ale` falls, `ram_a[7:0]` holds the last value seen on `mcu_ad_i` while ALE was high, whatever `mcu_ad_i` does afterwards, until ALE rises again.
- R3: `ram_a[15:8]` always equals `mcu_a_hi`.
- R4: `ram_a[17:16]` equals page register bits [1:0]. The page value used for a bus cycle is captured during that cycle's ALE phase, so a page write shows on the outputs only from the next bus cycle.
- R5: After synchronous reset the page register is 0. With ALE low, `ram_a[17:16]` reads 0 and the shared window selects internal RAM.
- R6: The page register loads `mcu_ad_i` on a rising clock edge only when `mcu_io`=1, `mcu_wr_n`=0 and the latched 16-bit address equals `PAGE_ADDR`. Memory writes (`mcu_io`=0) to that address and I/O writes to any other address leave the page unchanged.
- R7: A memory cycle (`mcu_io`=0) is in the window when `(mcu_a_hi & WIN_MASK) == WIN_MATCH`. In the window with page 0, `int_ram_sel`=1 and `ram_ce_n`=1. In the window with a nonzero page, `ram_ce_n`=0 and `int_ram_sel`=0. Outside the window, or during an I/O cycle, both are inactive.
- R8: `ram_oe_n` is low exactly when the external RAM is selected and `mcu_rd_n` is low. `ram_we_n` is low exactly when the external RAM is selected and `mcu_wr_n` is low.
- R9: During an external write, `ram_dq_oe`=1 and `ram_dq_o` equals `mcu_ad_i`. During an external read, `mcu_ad_oe`=1 and `mcu_ad_o` equals `ram_dq_i`. At all other times both enables are 0.
- R10: `int_ram_sel`=1 and `ram_ce_n`=0 never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcu_ad_i | input | 8 | Shared low-address/data byte from the processor |
| mcu_ad_o | output | 8 | Read data returned to the processor |
| mcu_ad_oe | output | 1 | Drive enable for `mcu_ad_o` |
| mcu_a_hi | input | 8 | High address byte |
| mcu_ale | input | 1 | Address latch enable, high during the address phase |
| mcu_rd_n | input | 1 | Read strobe, active low |
| mcu_wr_n | input | 1 | Write strobe, active low |
| mcu_io | input | 1 | 1 marks an I/O-space cycle, 0 a memory cycle |
| int_ram_sel | output | 1 | Internal RAM select for the shared window |
| ram_a | output | 18 | External RAM address |
| ram_dq_i | input | 8 | Data read from the external RAM |
| ram_dq_o | output | 8 | Data written to the external RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_o` |
| ram_ce_n | output | 1 | External RAM chip enable, active low |
| ram_oe_n | output | 1 | External RAM output enable, active low |
| ram_we_n | output | 1 | External RAM write enable, active low |

## Verification
The bench builds the block with a 4-bit page register, a window mask of 0xC0 matching 0x40, and the page port at 0x00F0. With these values the bench can write and check every page value. For each page it sweeps all 256 high-byte values, with a low byte derived from each one. That sweep covers addresses inside and outside the window, page zero against the nonzero pages, and both read and write strobes. It also exercises decoy writes to the page address in memory space and in nearby I/O addresses, the transparent and hold phases of the low-byte latch, and the one-cycle delay before a page write takes effect.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

    localparam int CPU_AW = 16;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_INT  = 2'd1,
        TGT_EXT  = 2'd2
    } target_t;

    typedef struct packed {
        logic io;
        logic rd;
        logic wr;
    } bus_ctl_t;

    function automatic logic hit_window(input byte_t hi, input byte_t mask,
                                        input byte_t match);
        return (hi & mask) == match;
    endfunction

endpackage

// File: rtl/pxb_addr_latch.sv
module pxb_addr_latch
    import pxb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ale,
    input  byte_t ad_i,
    output byte_t lo_addr
);
    byte_t lo_q;

    always_ff @(posedge clk) begin
        if (rst)      lo_q <= '0;
        else if (ale) lo_q <= ad_i;
    end

    // transparent during the address phase, held afterwards
    assign lo_addr = ale ? ad_i : lo_q;

    a_r2_low_hold: assert property (@(posedge clk) disable iff (rst)
        (!ale && $past(!ale)) |-> lo_addr == $past(lo_addr));

endmodule

// File: rtl/pxb_page_reg.sv
module pxb_page_reg
    import pxb_pkg::*;
#(
    parameter int                PAGE_W    = 8,
    parameter logic [CPU_AW-1:0] PAGE_ADDR = 16'h00F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  bus_ctl_t          ctl,
    input  logic [CPU_AW-1:0] addr,
    input  byte_t             wdata,
    output logic [PAGE_W-1:0] page_eff
);
    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] cyc_q;
    logic              hit;

    assign hit = ctl.io && ctl.wr && (addr == PAGE_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            cyc_q  <= '0;
        end else begin
            if (hit) page_q <= wdata[PAGE_W-1:0];
            if (ale) cyc_q  <= page_q;
        end
    end

    // cycle page follows the register only during the address phase
    assign page_eff = ale ? page_q : cyc_q;

    a_r5_reset_page: assert property (@(posedge clk)
        rst |=> page_q == '0);

    a_r4_page_stable_in_cycle: assert property (@(posedge clk) disable iff (rst)
        (!ale && $past(!ale)) |-> page_eff == $past(page_eff));

    a_r6_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        !ctl.io |=> page_q == $past(page_q));

endmodule

// File: rtl/pxb_decode.sv
module pxb_decode
    import pxb_pkg::*;
#(
    parameter int    PAGE_W    = 8,
    parameter byte_t WIN_MASK  = 8'h00,
    parameter byte_t WIN_MATCH = 8'h00
) (
    input  byte_t             hi,
    input  bus_ctl_t          ctl,
    input  logic [PAGE_W-1:0] page,
    output target_t           tgt
);
    always_comb begin
        tgt = TGT_NONE;
        if (!ctl.io && hit_window(hi, WIN_MASK, WIN_MATCH)) begin
            if (page == '0) tgt = TGT_INT;
            else            tgt = TGT_EXT;
        end
    end
endmodule

// File: rtl/paged_xram_bridge.sv
module paged_xram_bridge
    import pxb_pkg::*;
#(
    parameter int                PAGE_W    = 8,
    parameter int                EXT_W     = 2,
    parameter byte_t             WIN_MASK  = 8'h00,
    parameter byte_t             WIN_MATCH = 8'h00,
    parameter logic [CPU_AW-1:0] PAGE_ADDR = 16'h00F0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [7:0]                mcu_ad_i,
    output logic [7:0]                mcu_ad_o,
    output logic                      mcu_ad_oe,
    input  logic [7:0]                mcu_a_hi,
    input  logic                      mcu_ale,
    input  logic                      mcu_rd_n,
    input  logic                      mcu_wr_n,
    input  logic                      mcu_io,
    output logic                      int_ram_sel,
    output logic [CPU_AW+EXT_W-1:0]   ram_a,
    input  logic [7:0]                ram_dq_i,
    output logic [7:0]                ram_dq_o,
    output logic                      ram_dq_oe,
    output logic                      ram_ce_n,
    output logic                      ram_oe_n,
    output logic                      ram_we_n
);
    localparam int RAM_AW = CPU_AW + EXT_W;

    bus_ctl_t          ctl;
    byte_t             lo_addr;
    logic [PAGE_W-1:0] page_eff;
    target_t           tgt;
    logic              ext_sel;

    assign ctl = '{io: mcu_io, rd: !mcu_rd_n, wr: !mcu_wr_n};

    pxb_addr_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .ale     (mcu_ale),
        .ad_i    (mcu_ad_i),
        .lo_addr (lo_addr)
    );

    pxb_page_reg #(.PAGE_W(PAGE_W), .PAGE_ADDR(PAGE_ADDR)) u_page (
        .clk      (clk),
        .rst      (rst),
        .ale      (mcu_ale),
        .ctl      (ctl),
        .addr     ({mcu_a_hi, lo_addr}),
        .wdata    (mcu_ad_i),
        .page_eff (page_eff)
    );

    pxb_decode #(.PAGE_W(PAGE_W), .WIN_MASK(WIN_MASK), .WIN_MATCH(WIN_MATCH)) u_dec (
        .hi   (mcu_a_hi),
        .ctl  (ctl),
        .page (page_eff),
        .tgt  (tgt)
    );

    generate
        if (EXT_W > 0) begin : g_ext
            assign ram_a = {page_eff[EXT_W-1:0], mcu_a_hi, lo_addr};
        end else begin : g_noext
            assign ram_a = {mcu_a_hi, lo_addr};
        end
    endgenerate

    assign ext_sel     = (tgt == TGT_EXT);
    assign int_ram_sel = (tgt == TGT_INT);
    assign ram_ce_n    = !ext_sel;
    assign ram_oe_n    = !(ext_sel && ctl.rd);
    assign ram_we_n    = !(ext_sel && ctl.wr);
    assign ram_dq_o    = mcu_ad_i;
    assign ram_dq_oe   = ext_sel && ctl.wr;
    assign mcu_ad_o    = ram_dq_i;
    assign mcu_ad_oe   = ext_sel && ctl.rd;

    a_r10_exclusive_sel: assert property (@(posedge clk) disable iff (rst)
        !(int_ram_sel && !ram_ce_n));

    a_r8_oe_needs_ce: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |-> (!ram_ce_n && !mcu_rd_n));

    a_r8_we_needs_ce: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (!ram_ce_n && !mcu_wr_n));

    a_r7_io_no_select: assert property (@(posedge clk) disable iff (rst)
        mcu_io |-> (ram_ce_n && !int_ram_sel));

    a_r3_high_pass: assert property (@(posedge clk) disable iff (rst)
        ram_a[15:8] == mcu_a_hi);

    initial begin
        assert (RAM_AW == CPU_AW + EXT_W && PAGE_W >= EXT_W);
    end

endmodule

// File: tb/paged_xram_bridge_bench.sv
module paged_xram_bridge_bench;
    localparam int          PW    = 4;
    localparam logic [7:0]  MASK  = 8'hC0;
    localparam logic [7:0]  MATCH = 8'h40;
    localparam logic [15:0] PADDR = 16'h00F0;

    logic clk = 0, rst = 1;
    logic [7:0] ad_i = 0, a_hi = 0, dq_i = 0;
    logic ale = 0, rd_n = 1, wr_n = 1, io = 0;
    logic [7:0] ad_o, dq_o;
    logic ad_oe, dq_oe, int_sel, ce_n, oe_n, we_n;
    logic [17:0] ra;

    int n_chk = 0, n_fail = 0;
    logic [PW-1:0] exp_page = 0;

    always #10 clk = ~clk;

    paged_xram_bridge #(.PAGE_W(PW), .EXT_W(2), .WIN_MASK(MASK),
                        .WIN_MATCH(MATCH), .PAGE_ADDR(PADDR)) u_paged_xram_bridge (
        .clk(clk), .rst(rst), .mcu_ad_i(ad_i), .mcu_ad_o(ad_o), .mcu_ad_oe(ad_oe),
        .mcu_a_hi(a_hi), .mcu_ale(ale), .mcu_rd_n(rd_n), .mcu_wr_n(wr_n),
        .mcu_io(io), .int_ram_sel(int_sel), .ram_a(ra), .ram_dq_i(dq_i),
        .ram_dq_o(dq_o), .ram_dq_oe(dq_oe), .ram_ce_n(ce_n), .ram_oe_n(oe_n),
        .ram_we_n(we_n));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bus cycle; io write to PADDR updates exp_page after the strobe
    task automatic bus_cycle(input logic is_io, input logic [7:0] hi, input logic [7:0] lo,
                             input logic is_rd, input logic [7:0] data);
        logic [PW-1:0] pg;
        logic inwin, e_ext, e_int;
        @(negedge clk);
        io = is_io; a_hi = hi; ad_i = ~lo; ale = 1;
        #2 check("R1 transparent first", {24'd0, ra[7:0]}, {24'd0, ~lo});
        ad_i = lo;
        #2 check("R1 transparent follow", {24'd0, ra[7:0]}, {24'd0, lo});
        @(negedge clk);
        ale = 0; ad_i = data; dq_i = data ^ 8'hA5;
        pg = exp_page;
        inwin = (hi & MASK) == MATCH;
        e_ext = !is_io && inwin && pg != 0;
        e_int = !is_io && inwin && pg == 0;
        #2;
        check("R2 low held", {24'd0, ra[7:0]}, {24'd0, lo});
        check("R3 high pass", {24'd0, ra[15:8]}, {24'd0, hi});
        check("R4 page lines", {30'd0, ra[17:16]}, {30'd0, pg[1:0]});
        check("R7 int select", {31'd0, int_sel}, {31'd0, e_int});
        check("R7 ext select", {31'd0, ce_n}, {31'd0, !e_ext});
        check("R10 exclusive", {31'd0, int_sel & !ce_n}, 0);
        if (is_rd) rd_n = 0; else wr_n = 0;
        #2;
        check("R8 oe", {31'd0, oe_n}, {31'd0, !(e_ext && is_rd)});
        check("R8 we", {31'd0, we_n}, {31'd0, !(e_ext && !is_rd)});
        check("R9 ram drive", {31'd0, dq_oe}, {31'd0, e_ext && !is_rd});
        check("R9 mcu drive", {31'd0, ad_oe}, {31'd0, e_ext && is_rd});
        if (e_ext && is_rd)  check("R9 read data", {24'd0, ad_o}, {24'd0, data ^ 8'hA5});
        if (e_ext && !is_rd) check("R9 write data", {24'd0, dq_o}, {24'd0, data});
        @(negedge clk);
        if (is_io && !is_rd && {hi, lo} == PADDR) exp_page = data[PW-1:0];
        #2 check("R4 page delayed", {30'd0, ra[17:16]}, {30'd0, pg[1:0]});
        rd_n = 1; wr_n = 1;
        #2 check("R2 low held late", {24'd0, ra[7:0]}, {24'd0, lo});
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        check("R5 reset page lines", {30'd0, ra[17:16]}, 0);
        a_hi = MATCH; #2;
        check("R5 reset int select", {31'd0, int_sel}, 1);
        check("R5 reset ext off", {31'd0, ce_n}, 1);
        bus_cycle(0, MATCH, 8'h12, 1, 8'h33);
        // decoy writes must not touch the page (R6)
        bus_cycle(0, PADDR[15:8], PADDR[7:0], 0, 8'h07);
        bus_cycle(1, PADDR[15:8], PADDR[7:0] + 8'd1, 0, 8'h07);
        bus_cycle(1, 8'h01, PADDR[7:0], 0, 8'h07);
        bus_cycle(1, PADDR[15:8], PADDR[7:0], 1, 8'h07);
        bus_cycle(0, MATCH, 8'h00, 1, 8'h00);
        check("R6 decoys ignored", {30'd0, ra[17:16]}, 0);
        check("R6 decoys ignored sel", {31'd0, int_sel}, 1);
        for (int p = 0; p < (1 << PW); p++) begin
            bus_cycle(1, PADDR[15:8], PADDR[7:0], 0, 8'(p));
            for (int h = 0; h < 256; h++)
                bus_cycle(0, 8'(h), 8'(h) ^ 8'h5A, h[0], 8'(h * 3 + p));
        end
        bus_cycle(1, PADDR[15:8], PADDR[7:0], 0, 8'h00);
        bus_cycle(0, MATCH, 8'h77, 0, 8'h11);
        check("R6 page back to zero", {31'd0, int_sel}, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule